// File: doc/BRIEF.md
# System Clock Source Selector with Crystal Fallback

This block produces three clock-enable streams for a chip: an auxiliary clock, a master clock and a subsystem clock. All timing is carried on a single fast reference clock. Each candidate oscillator appears as a one-cycle enable pulse on that clock. Each output chooses its own source and then divides it by a power of two. There are six sources: a low-frequency crystal, an accurate internal reference, a very-low-power oscillator, a digitally controlled oscillator (DCO), a divided DCO tap that all three outputs share, and a high-frequency crystal.

The block holds its configuration in a small write-only register bus and comes out of reset with fixed defaults. It also watches both crystals. A crystal counts as usable only while its pin-function enable is set and its pulses keep arriving. When a crystal is unusable, any output that selects it falls back to another source. The fallback is the internal reference if that crystal is flagged as low-frequency, and the DCO otherwise. A sticky fault flag for each crystal records a lost crystal until software clears it.

Top module: `sysclk_mux`

## Requirements
- R1: Every output has a 3-bit source code: 0 low-frequency crystal, 1 internal reference, 2 very-low-power oscillator, 3 DCO, 4 divided DCO tap, 5 high-frequency crystal. Codes 6 and 7 behave as code 4.
- R2: The shared DCO tap divides the DCO pulses by 2^min(c,5), where c is its 3-bit divide code.
- R3: Each output divider counts the pulses of its effective source from zero. It emits one pulse on every 2^min(d,5)-th pulse, where d is its 3-bit divide code.
- R4: Reset state: auxiliary source 0, master and subsystem source 4, tap code 1, output divide codes 0, both pin enables clear, low-frequency crystal mode bit set, high-frequency mode bit clear, window length WIN_DEF. Neither crystal is valid and neither fault flag is set.
- R5: A crystal is invalid whenever its pin enable is clear. Clearing the pin enable makes the crystal invalid from the cycle in which the write takes effect.
- R6: With the pin enabled, a monitor window of the programmed length that holds no crystal pulse makes the crystal invalid and sets its sticky fault flag.
- R7: A crystal becomes valid only after GOOD_N consecutive windows, each holding at least one pulse, counted from the moment the pin is enabled. The window length comes from the window register, and a length of 0 acts as 1.
- R8: An output whose selected crystal is invalid takes the internal reference if that crystal's mode bit is 1 (low frequency), and the DCO if the bit is 0. This applies to all three outputs.
- R9: A fault flag stays set until a write to the clear register with its bit at 1. With the pin disabled it then stays clear.
- R10: A write that changes a divide field clears that divider's counter, and a source pulse in the same cycle is dropped. A write of an unchanged value leaves the counter as it is.
- R11: Register map. Address 0 holds the source codes: [2:0] auxiliary, [5:3] master, [8:6] subsystem. Address 1 holds the divide codes: [2:0] auxiliary, [5:3] master, [8:6] subsystem, [11:9] tap. Address 2 holds the crystal controls: [0] low-frequency pin enable, [1] low-frequency mode, [2] high-frequency pin enable, [3] high-frequency mode. Address 3 holds the window length. Address 4 is the fault clear: [0] low-frequency, [1] high-frequency. Writes to any other address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lfx_pulse | input | 1 | Low-frequency crystal enable pulse |
| ref_pulse | input | 1 | Internal reference enable pulse |
| vlo_pulse | input | 1 | Very-low-power oscillator enable pulse |
| dco_pulse | input | 1 | Controlled oscillator enable pulse |
| hfx_pulse | input | 1 | High-frequency crystal enable pulse |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register address |
| cfg_wdata | input | DATA_W | Register write data |
| aux_en | output | 1 | Auxiliary clock enable pulse |
| mst_en | output | 1 | Master clock enable pulse |
| sub_en | output | 1 | Subsystem clock enable pulse |
| lfx_ok | output | 1 | Low-frequency crystal currently valid |
| hfx_ok | output | 1 | High-frequency crystal currently valid |
| lfx_fault | output | 1 | Sticky low-frequency crystal fault |
| hfx_fault | output | 1 | Sticky high-frequency crystal fault |

## Verification
A divider restart and a source pulse can fall in the same cycle. The DCO pulses on every cycle, and before each measurement the divide register is written twice, first with every field's low bit flipped and then with the wanted value. Both writes therefore coincide with a DCO pulse on the tap and on any output that follows the DCO. Each measured count has to equal the exact floor quotient that a counter starting at zero gives, so a pulse that leaked through a restart would show as an off-by-one. A further case writes an unchanged divide value in the cycle of a counted pulse and expects the next terminal pulse one cycle later.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  localparam int SEL_W  = 3;
  localparam int DIVC_W = 3;
  localparam int CNT_W  = 5;   // largest divide is 2^5

  localparam logic [SEL_W-1:0] SRC_LFX  = 3'd0;
  localparam logic [SEL_W-1:0] SRC_REF  = 3'd1;
  localparam logic [SEL_W-1:0] SRC_VLO  = 3'd2;
  localparam logic [SEL_W-1:0] SRC_DCO  = 3'd3;
  localparam logic [SEL_W-1:0] SRC_DCOD = 3'd4;
  localparam logic [SEL_W-1:0] SRC_HFX  = 3'd5;

  // terminal count for a divide code: codes above CNT_W saturate
  function automatic logic [CNT_W-1:0] div_term(input logic [DIVC_W-1:0] code);
    logic [CNT_W-1:0] t;
    t = '0;
    for (int b = 0; b < CNT_W; b++)
      if (b < int'(code)) t[b] = 1'b1;
    return t;
  endfunction

  // effective source after alias folding and crystal fallback
  function automatic logic [SEL_W-1:0] resolve_src(
      input logic [SEL_W-1:0] sel,
      input logic lf_ok, input logic lf_low,
      input logic hf_ok, input logic hf_low);
    logic [SEL_W-1:0] s;
    s = (sel > SRC_HFX) ? SRC_DCOD : sel;
    if (s == SRC_LFX && !lf_ok) s = lf_low ? SRC_REF : SRC_DCO;
    if (s == SRC_HFX && !hf_ok) s = hf_low ? SRC_REF : SRC_DCO;
    return s;
  endfunction
endpackage

// File: rtl/sysclk_div.sv
module sysclk_div
  import sysclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              in_pulse,
  input  logic [DIVC_W-1:0] code,
  output logic              out_pulse
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] term;
  logic             at_term;

  assign term      = div_term(code);
  assign at_term   = (cnt == term);
  assign out_pulse = in_pulse && at_term;

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (restart)  cnt <= '0;
    else if (in_pulse) cnt <= at_term ? '0 : cnt + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= term); // R3
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0)); // R10
endmodule

// File: rtl/sysclk_xmon.sv
module sysclk_xmon #(
  parameter int WIN_W  = 8,
  parameter int GOOD_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_en,
  input  logic             pulse,
  input  logic [WIN_W-1:0] win_len,
  output logic             valid,
  output logic             fault_evt
);
  localparam int GC_W = $clog2(GOOD_N + 1);
  localparam logic [GC_W-1:0] GOOD_LIM = GC_W'(GOOD_N);

  logic [WIN_W-1:0] wcnt;
  logic [WIN_W-1:0] last;
  logic [GC_W-1:0]  gcnt;
  logic             seen, good, hit, win_end;

  assign last      = (win_len == '0) ? '0 : win_len - 1'b1;
  assign win_end   = pin_en && (wcnt >= last);
  assign hit       = seen || pulse;
  assign fault_evt = win_end && !hit;
  assign valid     = pin_en && good;

  always_ff @(posedge clk) begin
    if (!rst_n || !pin_en) begin
      wcnt <= '0; seen <= 1'b0; good <= 1'b0; gcnt <= '0;
    end else if (win_end) begin
      wcnt <= '0;
      seen <= 1'b0;
      if (hit) begin
        if (gcnt != GOOD_LIM) gcnt <= gcnt + 1'b1;
        if (gcnt >= GOOD_LIM - 1'b1) good <= 1'b1;
      end else begin
        gcnt <= '0;
        good <= 1'b0;
      end
    end else begin
      wcnt <= wcnt + 1'b1;
      seen <= hit;
    end
  end

  AST_FAULT_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> !valid); // R6
  AST_GOOD_AT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(good) |-> $past(win_end && hit)); // R7
endmodule

// File: rtl/sysclk_mux.sv
module sysclk_mux
  import sysclk_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 16,
  parameter int WIN_W   = 8,
  parameter int WIN_DEF = 16,
  parameter int GOOD_N  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lfx_pulse,
  input  logic              ref_pulse,
  input  logic              vlo_pulse,
  input  logic              dco_pulse,
  input  logic              hfx_pulse,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              aux_en,
  output logic              mst_en,
  output logic              sub_en,
  output logic              lfx_ok,
  output logic              hfx_ok,
  output logic              lfx_fault,
  output logic              hfx_fault
);
  localparam int N_OUT = 3;
  localparam int N_DIV = N_OUT + 1;   // index N_OUT is the shared tap

  logic [N_OUT-1:0][SEL_W-1:0]  sel_q;
  logic [N_DIV-1:0][DIVC_W-1:0] div_q;
  logic [N_DIV-1:0]             restart;
  logic [N_OUT-1:0][SEL_W-1:0]  eff_sel;
  logic [N_OUT-1:0]             out_vec;
  logic [7:0]                   src_vec;
  logic lf_pin, lf_low, hf_pin, hf_low;
  logic [WIN_W-1:0] win_q;
  logic tap_pulse, lf_fevt, hf_fevt;
  logic wr_sel, wr_div, wr_xtl, wr_win, wr_clr;

  assign wr_sel = cfg_we && (cfg_addr == ADDR_W'(0));
  assign wr_div = cfg_we && (cfg_addr == ADDR_W'(1));
  assign wr_xtl = cfg_we && (cfg_addr == ADDR_W'(2));
  assign wr_win = cfg_we && (cfg_addr == ADDR_W'(3));
  assign wr_clr = cfg_we && (cfg_addr == ADDR_W'(4));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= {SRC_DCOD, SRC_DCOD, SRC_LFX};
      div_q  <= {3'd1, 3'd0, 3'd0, 3'd0};
      lf_pin <= 1'b0; lf_low <= 1'b1;
      hf_pin <= 1'b0; hf_low <= 1'b0;
      win_q  <= WIN_W'(WIN_DEF);
      lfx_fault <= 1'b0; hfx_fault <= 1'b0;
    end else begin
      if (wr_sel) sel_q <= cfg_wdata[N_OUT*SEL_W-1:0];
      if (wr_div) div_q <= cfg_wdata[N_DIV*DIVC_W-1:0];
      if (wr_xtl) {hf_low, hf_pin, lf_low, lf_pin} <= cfg_wdata[3:0];
      if (wr_win) win_q <= cfg_wdata[WIN_W-1:0];
      if (wr_clr && cfg_wdata[0]) lfx_fault <= 1'b0;
      if (wr_clr && cfg_wdata[1]) hfx_fault <= 1'b0;
      if (lf_fevt) lfx_fault <= 1'b1;   // a new fault wins over a clear
      if (hf_fevt) hfx_fault <= 1'b1;
    end
  end

  sysclk_xmon #(.WIN_W(WIN_W), .GOOD_N(GOOD_N)) u_lf_mon (
    .clk(clk), .rst_n(rst_n), .pin_en(lf_pin), .pulse(lfx_pulse),
    .win_len(win_q), .valid(lfx_ok), .fault_evt(lf_fevt));
  sysclk_xmon #(.WIN_W(WIN_W), .GOOD_N(GOOD_N)) u_hf_mon (
    .clk(clk), .rst_n(rst_n), .pin_en(hf_pin), .pulse(hfx_pulse),
    .win_len(win_q), .valid(hfx_ok), .fault_evt(hf_fevt));

  genvar gi;
  generate
    for (gi = 0; gi < N_DIV; gi++) begin : g_rst
      assign restart[gi] = wr_div && (cfg_wdata[gi*DIVC_W +: DIVC_W] != div_q[gi]);
    end
  endgenerate

  sysclk_div u_tap (
    .clk(clk), .rst_n(rst_n), .restart(restart[N_OUT]), .in_pulse(dco_pulse),
    .code(div_q[N_OUT]), .out_pulse(tap_pulse));

  assign src_vec = {2'b00, hfx_pulse, tap_pulse, dco_pulse, vlo_pulse, ref_pulse, lfx_pulse};

  generate
    for (gi = 0; gi < N_OUT; gi++) begin : g_out
      assign eff_sel[gi] = resolve_src(sel_q[gi], lfx_ok, lf_low, hfx_ok, hf_low);
      sysclk_div u_div (
        .clk(clk), .rst_n(rst_n), .restart(restart[gi]), .in_pulse(src_vec[eff_sel[gi]]),
        .code(div_q[gi]), .out_pulse(out_vec[gi]));

      AST_NO_DEAD_LFX: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_sel[gi] == SRC_LFX) |-> lfx_ok); // R8
      AST_NO_DEAD_HFX: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_sel[gi] == SRC_HFX) |-> hfx_ok); // R8
    end
  endgenerate

  assign aux_en = out_vec[0];
  assign mst_en = out_vec[1];
  assign sub_en = out_vec[2];

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (lfx_fault && !(wr_clr && cfg_wdata[0])) |=> lfx_fault); // R9
endmodule

// File: tb/sysclk_mux_bench.sv
module sysclk_mux_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lfx = 1'b0, refp = 1'b0, vlo = 1'b0, dco = 1'b0, hfx = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic aux_en, mst_en, sub_en, lfx_ok, hfx_ok, lfx_fault, hfx_fault;

  int total = 0, bad = 0, tick = 0;
  int p_lf = 0, p_hf = 0;
  int n_lf, n_ref, n_vlo, n_dco, n_hf, n_aux, n_mst, n_sub;

  always #10 clk = ~clk;

  sysclk_mux u_sysclk_mux (
    .clk(clk), .rst_n(rst_n), .lfx_pulse(lfx), .ref_pulse(refp), .vlo_pulse(vlo),
    .dco_pulse(dco), .hfx_pulse(hfx), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .aux_en(aux_en), .mst_en(mst_en), .sub_en(sub_en),
    .lfx_ok(lfx_ok), .hfx_ok(hfx_ok), .lfx_fault(lfx_fault), .hfx_fault(hfx_fault));

  // periodic source pulses, changed just after each rising edge
  always @(posedge clk) begin
    #1;
    tick++;
    refp = (tick % 3 == 0);
    vlo  = (tick % 5 == 0);
    dco  = 1'b1;
    lfx  = (p_lf != 0) && (tick % p_lf == 0);
    hfx  = (p_hf != 0) && (tick % p_hf == 0);
  end

  function automatic int dv(input int c);
    return 1 << ((c > 5) ? 5 : c);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 16'(d);
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  // two writes that change every divide field: all counters restart
  task automatic resync(input int d);
    wr(1, d ^ 12'h249);
    wr(1, d);
  endtask

  task automatic measure(input int n);
    n_lf = 0; n_ref = 0; n_vlo = 0; n_dco = 0; n_hf = 0;
    n_aux = 0; n_mst = 0; n_sub = 0;
    repeat (n) begin
      @(negedge clk);
      n_lf += int'(lfx); n_ref += int'(refp); n_vlo += int'(vlo);
      n_dco += int'(dco); n_hf += int'(hfx);
      n_aux += int'(aux_en); n_mst += int'(mst_en); n_sub += int'(sub_en);
    end
  endtask

  function automatic int cnt_of(input int code);
    case (code)
      1: return n_ref;
      2: return n_vlo;
      default: return n_dco;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R0 actual=timeout expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R4 reset defaults: aux on absent crystal -> reference, others on DCO/2
    measure(256);
    chk("R4 lfx_ok", int'(lfx_ok), 0);
    chk("R4 hfx_ok", int'(hfx_ok), 0);
    chk("R4 faults", int'(lfx_fault) + int'(hfx_fault), 0);
    chk("R4 aux default (R8 fallback)", n_aux, n_ref);
    chk("R4 mst default tap/2", n_mst, n_dco / 2);
    chk("R4 sub default tap/2", n_sub, n_dco / 2);

    // R1 R3 R10: sources rotated over outputs, every divide code
    for (int rot = 0; rot < 3; rot++) begin
      wr(0, (1 + rot % 3) | ((1 + (rot + 1) % 3) << 3) | ((1 + (rot + 2) % 3) << 6));
      for (int d = 0; d < 8; d++) begin
        resync(d | (d << 3) | (d << 6) | (1 << 9));
        measure(256);
        chk($sformatf("R3 aux src%0d d%0d", 1 + rot % 3, d), n_aux, cnt_of(1 + rot % 3) / dv(d));
        chk($sformatf("R3 mst src%0d d%0d", 1 + (rot + 1) % 3, d), n_mst, cnt_of(1 + (rot + 1) % 3) / dv(d));
        chk($sformatf("R1 sub src%0d d%0d", 1 + (rot + 2) % 3, d), n_sub, cnt_of(1 + (rot + 2) % 3) / dv(d));
      end
    end

    // R2 tap sweep; codes 6 and 7 alias the tap (R1)
    wr(0, 7 | (4 << 3) | (6 << 6));
    for (int t = 0; t < 8; t++) begin
      resync(0 | (0 << 3) | (2 << 6) | (t << 9));
      measure(256);
      chk($sformatf("R2 aux code7 tap%0d", t), n_aux, n_dco / dv(t));
      chk($sformatf("R2 mst tap%0d", t), n_mst, n_dco / dv(t));
      chk($sformatf("R1 sub code6 tap%0d", t), n_sub, (n_dco / dv(t)) / 4);
    end

    // R10: unchanged divide write in a pulse cycle keeps the count
    wr(0, 3);
    wr(1, 1 ^ 12'h249);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = 3'd1; cfg_wdata = 16'd1;
    @(posedge clk); #1;            // counter restarted; same value written again
    @(negedge clk);
    chk("R10 first counted cycle", int'(aux_en), 0);
    @(posedge clk); #1 cfg_we = 1'b0;
    @(negedge clk);
    chk("R10 same value keeps count", int'(aux_en), 1);

    // R5 R7: low-frequency crystal comes up
    p_lf = 2;
    wr(2, 4'b0011);
    repeat (60) @(negedge clk);
    chk("R7 lf valid after good windows", int'(lfx_ok), 1);
    wr(0, 0 | (0 << 3) | (5 << 6));
    resync(0);
    measure(256);
    chk("R1 aux on lf crystal", n_aux, n_lf);
    chk("R1 mst on lf crystal", n_mst, n_lf);
    chk("R8 sub absent hf, mode 0 -> dco", n_sub, n_dco);

    // high-frequency crystal
    p_hf = 6;
    wr(2, 4'b0111);
    repeat (60) @(negedge clk);
    chk("R7 hf valid", int'(hfx_ok), 1);
    resync(0);
    measure(256);
    chk("R1 sub on hf crystal", n_sub, n_hf);

    // R6 R8: lf crystal stops
    p_lf = 0;
    repeat (60) @(negedge clk);
    chk("R6 lf invalid", int'(lfx_ok), 0);
    chk("R6 lf fault set", int'(lfx_fault), 1);
    chk("R6 hf fault untouched", int'(hfx_fault), 0);
    resync(0);
    measure(256);
    chk("R8 aux low mode -> ref", n_aux, n_ref);
    chk("R8 mst low mode -> ref", n_mst, n_ref);
    wr(2, 4'b0101);
    resync(0);
    measure(256);
    chk("R8 aux high mode -> dco", n_aux, n_dco);
    chk("R9 fault still set", int'(lfx_fault), 1);

    // R9 clear with pin disabled
    wr(2, 4'b0100);
    wr(4, 1);
    repeat (60) @(negedge clk);
    chk("R9 fault cleared", int'(lfx_fault), 0);

    // R5 pin removal takes effect at once
    wr(2, 4'b0000);
    @(negedge clk);
    chk("R5 hf invalid on pin clear", int'(hfx_ok), 0);

    // R7 recovery timing with default window
    p_lf = 2;
    wr(2, 4'b0011);
    repeat (20) @(negedge clk);
    chk("R7 lf not yet valid", int'(lfx_ok), 0);
    repeat (30) @(negedge clk);
    chk("R7 lf valid", int'(lfx_ok), 1);

    // R11 window register, then an ignored address
    wr(2, 4'b0000);
    wr(3, 4);
    wr(2, 4'b0011);
    repeat (12) @(negedge clk);
    chk("R11 short window revalidates", int'(lfx_ok), 1);
    wr(7, 16'hFFFF);
    resync(0);
    measure(256);
    chk("R11 unmapped write ignored", n_aux, n_lf);
    chk("R11 lf still valid", int'(lfx_ok), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule